// File: doc/BRIEF.md
# Peripheral Interrupt Mask and Latch Controller

This block collects a set of peripheral interrupt request lines and folds them onto a smaller number of general-purpose core event inputs. Each source has three controls: a mask bit, a live status bit and a wakeup-enable bit. It also has a programmable entry that names the event the source drives. The unmasked requests that share an event are ORed into one combined event line.

Each event has a two-stage edge detector and a latch. The latch records a rising edge on the combined line and presents it to the core as a pending request. The request holds until the core acknowledges entry into service. Further pulses that arrive while the request is held merge into it. Once the acknowledge is seen, a fresh rising edge is captured again, even an edge in the same cycle as the acknowledge.

A wakeup output goes high when the core reports idle and any source with wakeup enabled is requesting. Software reaches the block through a small register bus. Writes take effect on the clock edge, and reads are combinational.

Top module: `irq_event_ctrl`

## Requirements
- R1: A source whose mask bit (register 0x00, bit i for source i) is 0 never sets any event latch. A source whose mask bit is 1 drives its mapped event line.
- R2: The status register (0x01, read-only) returns bit i equal to the live level of request i, whatever the mask. Writes to 0x01 change neither the mask nor the wakeup register.
- R3: The wakeup output equals core_idle AND the OR over all sources of (request AND wakeup-enable bit, register 0x02). It does not depend on the mask.
- R4: Map entry i sits at address 0x20+i and holds the event index of source i in its low bits. After reset, entry i holds i modulo NUM_EVT. A written entry reads back and redirects the source.
- R5: Unmasked sources that map to the same event are ORed. A second source rising while another source already holds the line high produces no new edge.
- R6: When the combined line of event e rises, evt_pend[e] is still 0 after the first clock edge and is 1 after the second.
- R7: A set evt_pend[e] stays set until evt_ack[e] is sampled high. Extra rising edges before then merge into the same request, so one acknowledge clears all of them.
- R8: A sampled evt_ack[e] clears evt_pend[e] unless a new rising edge is detected on that event in the same cycle, in which case the bit stays set. Any later rising edge sets it again.
- R9: After reset, the mask and wakeup-enable registers read 0, all evt_pend bits are 0 and wake_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Peripheral request levels |
| core_idle | input | 1 | Core is idle or asleep |
| evt_ack | input | NUM_EVT | Core acknowledge, one per event |
| evt_pend | output | NUM_EVT | Latched pending request per event |
| wake_o | output | 1 | Wakeup request to the core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data (combinational) |

## Verification
The bench samples evt_pend one edge and two edges after a line rises. A detector with one stage too many or too few fails that check, and so does a detector that tracks level instead of edge. An acknowledge is driven in the same cycle as a new edge: a design that lets the clear win drops that event. A second pulse is sent before the acknowledge: a design that counts pulses instead of merging them leaves a request pending after the acknowledge. Masked requests, sources sharing an event, a remapped source and a write to the read-only status register expose masking applied after the OR, routing that ignores the table, or a status write that corrupts the mask or wakeup registers.

// File: rtl/irq_pkg.sv
// Package: shared address map and bus widths for the interrupt controller.
// Assumes reg_addr is ADDR_W bits wide and map entries start at MAP_BASE.
package irq_pkg;
    localparam int ADDR_W    = 6;
    localparam int MAP_BASE  = 32;
    localparam logic [ADDR_W-1:0] A_MASK   = 6'h00;
    localparam logic [ADDR_W-1:0] A_STATUS = 6'h01;
    localparam logic [ADDR_W-1:0] A_WAKE   = 6'h02;
endpackage

// File: rtl/irq_regs.sv
// irq_regs: mask, wakeup-enable and source-to-event map registers with a
// combinational read port. Assumes NUM_SRC <= MAP_BASE so map addresses fit.
module irq_regs
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_EVT = 4,
    parameter int EVT_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [NUM_SRC-1:0]       reg_wdata,
    input  logic [NUM_SRC-1:0]       irq_req,
    output logic [NUM_SRC-1:0]       reg_rdata,
    output logic [NUM_SRC-1:0]       mask_q,
    output logic [NUM_SRC-1:0]       wake_q,
    output logic [NUM_SRC*EVT_W-1:0] map_flat
);
    logic [EVT_W-1:0] map_q [NUM_SRC];

    // Mask and wakeup-enable registers; status has no storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            wake_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_MASK) mask_q <= reg_wdata;
            if (reg_addr == A_WAKE) wake_q <= reg_wdata;
        end
    end

    // One map entry per source, reset to source index modulo event count.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[i] <= EVT_W'(i % NUM_EVT);
            else if (reg_we && reg_addr == ADDR_W'(MAP_BASE + i))
                map_q[i] <= reg_wdata[EVT_W-1:0];
        end
        assign map_flat[i*EVT_W +: EVT_W] = map_q[i];
    end

    // Read mux over the register map.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MASK:   reg_rdata = mask_q;
            A_STATUS: reg_rdata = irq_req;
            A_WAKE:   reg_rdata = wake_q;
            default: begin
                for (int i = 0; i < NUM_SRC; i++)
                    if (reg_addr == ADDR_W'(MAP_BASE + i))
                        reg_rdata = NUM_SRC'(map_q[i]);
            end
        endcase
    end

    // R2: a write to the status address leaves mask and wakeup untouched.
    assert_status_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STATUS) |=> ($stable(mask_q) && $stable(wake_q)));
endmodule

// File: rtl/irq_router.sv
// irq_router: applies the per-source mask, then ORs each unmasked request
// into the event its map entry names. Pure combinational logic.
module irq_router #(
    parameter int NUM_SRC = 16,
    parameter int NUM_EVT = 4,
    parameter int EVT_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       irq_req,
    input  logic [NUM_SRC-1:0]       mask_q,
    input  logic [NUM_SRC*EVT_W-1:0] map_flat,
    output logic [NUM_EVT-1:0]       evt_line
);
    logic [NUM_SRC-1:0] masked;
    assign masked = irq_req & mask_q;

    // Fold each unmasked request onto its mapped event line.
    always_comb begin
        evt_line = '0;
        for (int e = 0; e < NUM_EVT; e++)
            for (int s = 0; s < NUM_SRC; s++)
                if (masked[s] && map_flat[s*EVT_W +: EVT_W] == EVT_W'(e))
                    evt_line[e] = 1'b1;
    end

    // R1: with every source masked no event line may be high.
    assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (evt_line == '0));
endmodule

// File: rtl/irq_edge_latch.sv
// irq_edge_latch: per-event two-stage rising-edge detector and pending latch
// cleared by the core acknowledge; a rise in the acknowledge cycle wins.
module irq_edge_latch #(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_line,
    input  logic [NUM_EVT-1:0] evt_ack,
    output logic [NUM_EVT-1:0] evt_pend
);
    logic [NUM_EVT-1:0] stg1, stg2, rise;

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        assign rise[e] = stg1[e] & ~stg2[e];

        // Two sampling stages and the pending latch for this event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg1[e]     <= 1'b0;
                stg2[e]     <= 1'b0;
                evt_pend[e] <= 1'b0;
            end else begin
                stg1[e]     <= evt_line[e];
                stg2[e]     <= stg1[e];
                evt_pend[e] <= (evt_pend[e] & ~evt_ack[e]) | rise[e];
            end
        end

        // R7: an unacknowledged request is held.
        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_pend[e] && !evt_ack[e]) |=> evt_pend[e]);
        // R8: acknowledge without a new edge clears the request.
        assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_ack[e] && !rise[e]) |=> !evt_pend[e]);
        // R8: a new edge in the acknowledge cycle keeps it queued.
        assert_ack_requeue_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_ack[e] && rise[e]) |=> evt_pend[e]);
        // R6: no request appears without a detected edge.
        assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_pend[e] && !rise[e]) |=> !evt_pend[e]);
    end
endmodule

// File: rtl/irq_event_ctrl.sv
// irq_event_ctrl: top of the peripheral interrupt mask and latch controller.
// Joins registers, routing, per-event latches and the wakeup OR.
// Assumes NUM_SRC <= 32 so map entries fit the 6-bit address space.
module irq_event_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               core_idle,
    input  logic [NUM_EVT-1:0] evt_ack,
    output logic [NUM_EVT-1:0] evt_pend,
    output logic               wake_o,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata
);
    localparam int EVT_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic [NUM_SRC-1:0]       mask_q, wake_q;
    logic [NUM_SRC*EVT_W-1:0] map_flat;
    logic [NUM_EVT-1:0]       evt_line;

    irq_regs #(.NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_req(irq_req), .reg_rdata(reg_rdata),
        .mask_q(mask_q), .wake_q(wake_q), .map_flat(map_flat));

    irq_router #(.NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u_route (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_q(mask_q),
        .map_flat(map_flat), .evt_line(evt_line));

    irq_edge_latch #(.NUM_EVT(NUM_EVT)) u_latch (
        .clk(clk), .rst_n(rst_n), .evt_line(evt_line), .evt_ack(evt_ack),
        .evt_pend(evt_pend));

    // Wakeup: any wake-enabled request while the core is idle.
    assign wake_o = core_idle & (|(irq_req & wake_q));

    // R3: the wakeup output is never raised for an active core.
    assert_wake_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !core_idle |-> !wake_o);
    // R3: the wakeup output needs a live request.
    assert_wake_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req == '0) |-> !wake_o);
endmodule

// File: tb/sim_irq_event_ctrl.sv
`timescale 1ns/100ps
module sim_irq_event_ctrl;
    localparam int NS = 16;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic          core_idle = 1'b0;
    logic [NE-1:0] evt_ack = '0;
    logic [NE-1:0] evt_pend;
    logic          wake_o;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_event_ctrl #(.NUM_SRC(NS), .NUM_EVT(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_idle(core_idle),
        .evt_ack(evt_ack), .evt_pend(evt_pend), .wake_o(wake_o),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [NS-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [NS-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack(input int e);
        evt_ack[e] = 1'b1;
        step(1);
        evt_ack[e] = 1'b0;
    endtask

    task automatic t_reset;
        logic [NS-1:0] d;
        rd(6'h00, d); chk("R9 mask after reset", 32'(d), 0);
        rd(6'h02, d); chk("R9 wake-enable after reset", 32'(d), 0);
        chk("R9 pend after reset", 32'(evt_pend), 0);
        chk("R9 wake_o after reset", 32'(wake_o), 0);
        rd(6'h26, d); chk("R4 default map of source 6", 32'(d), 2);
    endtask

    task automatic t_mask;
        logic [NS-1:0] d;
        irq_req[3] = 1'b1;
        step(4);
        chk("R1 masked source sets no latch", 32'(evt_pend), 0);
        rd(6'h01, d); chk("R2 status shows masked request", 32'(d), 32'h8);
        irq_req[3] = 1'b0;
        step(1);
    endtask

    task automatic t_latch_merge;
        wr(6'h00, '1);
        irq_req[2] = 1'b1;
        step(1);
        chk("R6 pend still low after one edge", 32'(evt_pend[2]), 0);
        step(1);
        chk("R6 pend high after two edges", 32'(evt_pend[2]), 1);
        chk("R1 unmasked only its own event", 32'(evt_pend), 32'h4);
        irq_req[2] = 1'b0; step(2);
        irq_req[2] = 1'b1; step(3);
        chk("R7 held before ack", 32'(evt_pend[2]), 1);
        ack(2);
        chk("R7 merged pulses cleared by one ack", 32'(evt_pend[2]), 0);
        step(3);
        chk("R7 no second request after merge", 32'(evt_pend[2]), 0);
        irq_req[2] = 1'b0; step(2);
    endtask

    task automatic t_ack_race;
        irq_req[0] = 1'b1; step(2);
        chk("R6 event 0 pending", 32'(evt_pend[0]), 1);
        irq_req[0] = 1'b0; step(2);
        irq_req[0] = 1'b1; step(1);
        ack(0);
        chk("R8 rise in ack cycle stays queued", 32'(evt_pend[0]), 1);
        ack(0);
        chk("R8 second ack clears", 32'(evt_pend[0]), 0);
        irq_req[0] = 1'b0; step(2);
        irq_req[0] = 1'b1; step(2);
        chk("R8 later edge sets again", 32'(evt_pend[0]), 1);
        ack(0);
        chk("R8 ack clears re-queued", 32'(evt_pend[0]), 0);
        irq_req[0] = 1'b0; step(2);
    endtask

    task automatic t_share;
        irq_req[1] = 1'b1; step(2);
        chk("R5 source 1 sets event 1", 32'(evt_pend[1]), 1);
        ack(1);
        irq_req[5] = 1'b1; step(3);
        chk("R5 shared line gives no new edge", 32'(evt_pend[1]), 0);
        irq_req[1] = 1'b0; step(3);
        chk("R5 line held by source 5", 32'(evt_pend[1]), 0);
        irq_req[5] = 1'b0; step(2);
    endtask

    task automatic t_map;
        logic [NS-1:0] d;
        wr(6'h25, 16'h3);
        rd(6'h25, d); chk("R4 map readback", 32'(d), 3);
        irq_req[5] = 1'b1; step(2);
        chk("R4 remapped source hits event 3", 32'(evt_pend), 32'h8);
        ack(3);
        irq_req[5] = 1'b0; step(2);
    endtask

    task automatic t_wake;
        wr(6'h00, '0);
        wr(6'h02, 16'h0080);
        irq_req[7] = 1'b1; core_idle = 1'b0; #1;
        chk("R3 no wake while core active", 32'(wake_o), 0);
        core_idle = 1'b1; #1;
        chk("R3 wake with mask cleared", 32'(wake_o), 1);
        irq_req = 16'h0100; #1;
        chk("R3 source without enable gives no wake", 32'(wake_o), 0);
        irq_req = '0; core_idle = 1'b0;
        step(1);
    endtask

    task automatic t_status_ro;
        logic [NS-1:0] d;
        irq_req = 16'h0081;
        wr(6'h01, '1);
        rd(6'h00, d); chk("R2 status write leaves mask", 32'(d), 0);
        rd(6'h02, d); chk("R2 status write leaves wake-enable", 32'(d), 32'h80);
        rd(6'h01, d); chk("R2 status is live request", 32'(d), 32'h81);
        irq_req = '0;
        step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_mask();
        t_latch_merge();
        t_ack_race();
        t_share();
        t_map();
        t_wake();
        t_status_ro();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule